// File: doc/BRIEF.md
# Bus Fault Capture Register

This block keeps a 16-bit record of the faults seen on the system bus. When a bus cycle ends, which the bus-busy line shows by going from low to high, the block samples three active-low error lines. A cycle-owner qualifier and a memory-or-I/O qualifier then choose which bit each error sets. The block records cycles that other bus masters run as well as cycles the core runs. Two asynchronous system-fault inputs are also captured: each is synchronized, and its rising edge sets fixed bits in the register.

Bits follow the bus numbering convention, so bus bit 0 is the most significant bit of the register (vector index 15). Once set, a bit stays set until the core pulses a clear. The clear is the core's read-and-clear operation. If a new fault arrives in the same clock as the clear, the new fault is recorded. A flag output shows whether any bit is set.

Top module: `fault_capture_reg`

## Requirements
- R1: After reset, `fault_word` is 0 and `fault_any` is 0.
- R2: If `prot_err_n` is low while `busy_n` is low, in a cycle with `cpu_cycle`=1, then bus bit 0 (vector bit 15) is set on the clock edge where `busy_n` is first sampled high.
- R3: The same protect error in a cycle with `cpu_cycle`=0 (another master's cycle) sets bus bit 1 (vector bit 14) and does not set bus bit 0.
- R4: A `parity_err_n` low during the busy-low phase sets bus bit 2 (vector bit 13), whatever the values of the cycle qualifiers.
- R5: An `addr_err_n` low during the busy-low phase sets bus bit 5 (vector bit 10) when `mem_cycle`=1, and bus bit 8 (vector bit 7) when `mem_cycle`=0.
- R6: An error line that is active while no low-to-high transition of `busy_n` takes place has no effect on `fault_word`.
- R7: A rising edge on `sysflt0` sets bus bit 7 (vector bit 8) on the third clock edge after the edge is applied. Holding the input high does not set the bit again after a clear.
- R8: A rising edge on `sysflt1` sets bus bits 13 and 15 (vector bits 2 and 0) together, with the same latency as R7.
- R9: Set bits stay set until `clear` is high on a clock edge. That edge makes `fault_word` 0 unless a new fault arrives on the same edge.
- R10: A fault that arrives on the same edge as `clear` is held in the register after that edge, and every earlier bit is removed.
- R11: `fault_any` is 1 exactly when `fault_word` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_n | input | 1 | Bus busy, active low; a rising transition ends a cycle |
| cpu_cycle | input | 1 | 1 when this core owns the current cycle |
| mem_cycle | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| prot_err_n | input | 1 | Memory-protect error, active low |
| parity_err_n | input | 1 | Memory-parity error, active low |
| addr_err_n | input | 1 | External-address error, active low |
| sysflt0 | input | 1 | Asynchronous system fault 0, rising-edge sensitive |
| sysflt1 | input | 1 | Asynchronous system fault 1, rising-edge sensitive |
| clear | input | 1 | Read-and-clear pulse from the core |
| fault_word | output | 16 | Fault register, bus bit n at vector index 15-n |
| fault_any | output | 1 | 1 when any fault bit is set |

## Verification
The assertions assume the following about the inputs:
- `busy_n`, the error lines and the qualifiers are synchronous to `clk`.
- The error lines and qualifiers hold steady during the busy-low phase.
- The asynchronous fault inputs stay at each level for more than one clock.

The stimulus keeps to these assumptions. It changes every input at the falling clock edge. Each bus cycle holds `busy_n` low for a full clock with steady qualifiers. The system-fault inputs are held for several clocks. The sweep covers all 32 combinations of the three error lines and the two qualifiers.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int unsigned WORD_W = 16;

  // bus-convention bit numbers (bit 0 is the most significant)
  localparam int unsigned BN_PROT_OWN   = 0;
  localparam int unsigned BN_PROT_OTHER = 1;
  localparam int unsigned BN_PARITY     = 2;
  localparam int unsigned BN_ADDR_MEM   = 5;
  localparam int unsigned BN_SYS0       = 7;
  localparam int unsigned BN_ADDR_IO    = 8;
  localparam int unsigned BN_SYS1_A     = 13;
  localparam int unsigned BN_SYS1_B     = 15;

  typedef logic [WORD_W-1:0] fault_word_t;

  function automatic fault_word_t bus_bit(input int unsigned n);
    fault_word_t w;
    w = '0;
    w[WORD_W-1-n] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/fcr_edge_sync.sv
module fcr_edge_sync #(
  parameter int unsigned CHANNELS = 2,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] async_in,
  output logic [CHANNELS-1:0] rise_pulse
);
  localparam int unsigned DEPTH = STAGES + 1;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    logic [DEPTH-1:0] chain_q;
    logic [DEPTH-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[DEPTH-2:0], async_in[c]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign rise_pulse[c] = chain_q[STAGES-1] & ~chain_q[STAGES];

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pulse[c] |=> !rise_pulse[c]); // R7
  end
endmodule

// File: rtl/fcr_cycle_sampler.sv
module fcr_cycle_sampler
  import fcr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busy_n,
  input  logic        cpu_cycle,
  input  logic        mem_cycle,
  input  logic        prot_err_n,
  input  logic        parity_err_n,
  input  logic        addr_err_n,
  output logic        cycle_end,
  output fault_word_t cycle_set
);
  logic busy_n_q;
  logic prot_q, par_q, addr_q, cpu_q, mem_q;
  logic capture_en;

  // hold qualifiers and errors while the cycle is in progress
  assign capture_en = ~busy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_n_q <= 1'b1;
    else        busy_n_q <= busy_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      par_q  <= 1'b0;
      addr_q <= 1'b0;
      cpu_q  <= 1'b0;
      mem_q  <= 1'b0;
    end else if (capture_en) begin
      prot_q <= ~prot_err_n;
      par_q  <= ~parity_err_n;
      addr_q <= ~addr_err_n;
      cpu_q  <= cpu_cycle;
      mem_q  <= mem_cycle;
    end
  end

  assign cycle_end = busy_n & ~busy_n_q;

  always_comb begin
    cycle_set = '0;
    if (cycle_end) begin
      if (prot_q) cycle_set = cycle_set | bus_bit(cpu_q ? BN_PROT_OWN : BN_PROT_OTHER);
      if (par_q)  cycle_set = cycle_set | bus_bit(BN_PARITY);
      if (addr_q) cycle_set = cycle_set | bus_bit(mem_q ? BN_ADDR_MEM : BN_ADDR_IO);
    end
  end

  AST_PROT_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cycle_set[WORD_W-1-BN_PROT_OWN], cycle_set[WORD_W-1-BN_PROT_OTHER]})); // R3
  AST_ADDR_ONE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cycle_set[WORD_W-1-BN_ADDR_MEM], cycle_set[WORD_W-1-BN_ADDR_IO]})); // R5
  AST_SET_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_end |-> cycle_set == '0); // R6
endmodule

// File: rtl/fault_capture_reg.sv
module fault_capture_reg
  import fcr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_n,
  input  logic              cpu_cycle,
  input  logic              mem_cycle,
  input  logic              prot_err_n,
  input  logic              parity_err_n,
  input  logic              addr_err_n,
  input  logic              sysflt0,
  input  logic              sysflt1,
  input  logic              clear,
  output logic [WORD_W-1:0] fault_word,
  output logic              fault_any
);
  localparam int unsigned NUM_SYS = 2;

  logic [NUM_SYS-1:0] sys_pulse;
  logic               cycle_end;
  fault_word_t        cycle_set;
  fault_word_t        sys_set;
  fault_word_t        set_mask;
  fault_word_t        word_q, word_d;
  logic               word_en;

  fcr_edge_sync #(.CHANNELS(NUM_SYS), .STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_in   ({sysflt1, sysflt0}),
    .rise_pulse (sys_pulse)
  );

  fcr_cycle_sampler u_cyc (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_n       (busy_n),
    .cpu_cycle    (cpu_cycle),
    .mem_cycle    (mem_cycle),
    .prot_err_n   (prot_err_n),
    .parity_err_n (parity_err_n),
    .addr_err_n   (addr_err_n),
    .cycle_end    (cycle_end),
    .cycle_set    (cycle_set)
  );

  always_comb begin
    sys_set = '0;
    if (sys_pulse[0]) sys_set = sys_set | bus_bit(BN_SYS0);
    if (sys_pulse[1]) sys_set = sys_set | bus_bit(BN_SYS1_A) | bus_bit(BN_SYS1_B);
  end

  always_comb begin
    set_mask = cycle_set | sys_set;
    word_en  = clear | (|set_mask);
    word_d   = (clear ? '0 : word_q) | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  assign fault_word = word_q;
  assign fault_any  = |word_q;

  AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (fault_word & $past(fault_word)) == $past(fault_word)); // R9
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear && !cycle_end && sys_pulse == '0 |=> fault_word == '0); // R9
  AST_NEW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> fault_word == $past(set_mask)); // R10
  AST_SYS1_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    fault_word[WORD_W-1-BN_SYS1_A] == fault_word[WORD_W-1-BN_SYS1_B]); // R8
  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !clear && !cycle_end && sys_pulse == '0 |=> $stable(fault_word)); // R6
endmodule

// File: tb/fault_capture_reg_tb.sv
`timescale 1ns/1ps
module fault_capture_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        busy_n, cpu_cycle, mem_cycle;
  logic        prot_err_n, parity_err_n, addr_err_n;
  logic        sysflt0, sysflt1, clear;
  logic [15:0] fault_word;
  logic        fault_any;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  fault_capture_reg u_dut (
    .clk(clk), .rst_n(rst_n), .busy_n(busy_n), .cpu_cycle(cpu_cycle),
    .mem_cycle(mem_cycle), .prot_err_n(prot_err_n), .parity_err_n(parity_err_n),
    .addr_err_n(addr_err_n), .sysflt0(sysflt0), .sysflt1(sysflt1),
    .clear(clear), .fault_word(fault_word), .fault_any(fault_any)
  );

  function automatic logic [15:0] bb(input int n);
    return 16'h8000 >> n;
  endfunction

  task automatic check(input logic [15:0] exp, input string req);
    checks++;
    if (fault_word !== exp) begin
      errors++;
      $display("FAIL %s: fault_word=%h expected %h", req, fault_word, exp);
    end
    checks++;
    if (fault_any !== (exp != 0)) begin
      errors++;
      $display("FAIL R11 (%s): fault_any=%b expected %b", req, fault_any, exp != 0);
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  // one clock of busy low, then busy high; result visible at the following negedge
  task automatic bus_cycle(input logic p, input logic q, input logic a,
                           input logic cpu, input logic mem);
    @(negedge clk);
    busy_n = 1'b0; prot_err_n = p; parity_err_n = q; addr_err_n = a;
    cpu_cycle = cpu; mem_cycle = mem;
    @(negedge clk);
    busy_n = 1'b1; prot_err_n = 1'b1; parity_err_n = 1'b1; addr_err_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; busy_n = 1'b1; cpu_cycle = 1'b0; mem_cycle = 1'b0;
    prot_err_n = 1'b1; parity_err_n = 1'b1; addr_err_n = 1'b1;
    sysflt0 = 1'b0; sysflt1 = 1'b0; clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(16'h0000, "R1 reset");

    // sweep every error/qualifier combination: R2 R3 R4 R5
    for (int v = 0; v < 32; v++) begin
      logic p, q, a, cpu, mem;
      logic [15:0] exp;
      {p, q, a, cpu, mem} = v[4:0];
      exp = 16'h0;
      if (!p) exp |= cpu ? bb(0) : bb(1);
      if (!q) exp |= bb(2);
      if (!a) exp |= mem ? bb(5) : bb(8);
      bus_cycle(p, q, a, cpu, mem);
      check(exp, "R2/R3/R4/R5 cycle capture");
      do_clear();
      check(16'h0000, "R9 clear");
    end

    // R6: errors held active with busy low throughout, then high throughout
    @(negedge clk);
    busy_n = 1'b0; prot_err_n = 1'b0; parity_err_n = 1'b0; addr_err_n = 1'b0;
    cpu_cycle = 1'b1; mem_cycle = 1'b1;
    repeat (4) @(negedge clk);
    check(16'h0000, "R6 no end while busy low");
    prot_err_n = 1'b1; parity_err_n = 1'b1; addr_err_n = 1'b1;
    @(negedge clk); busy_n = 1'b1;
    @(negedge clk);
    check(16'h0000, "R6 end with errors gone");
    prot_err_n = 1'b0; parity_err_n = 1'b0; addr_err_n = 1'b0;
    repeat (4) @(negedge clk);
    check(16'h0000, "R6 errors while idle");
    prot_err_n = 1'b1; parity_err_n = 1'b1; addr_err_n = 1'b1;

    // R7: latency of three edges
    @(negedge clk); sysflt0 = 1'b1;
    @(negedge clk);
    check(16'h0000, "R7 not yet after 1 edge");
    @(negedge clk);
    check(16'h0000, "R7 not yet after 2 edges");
    @(negedge clk);
    check(bb(7), "R7 sysflt0 set");
    repeat (3) @(negedge clk);
    do_clear();
    repeat (4) @(negedge clk);
    check(16'h0000, "R7 held level no retrigger");
    sysflt0 = 1'b0;
    repeat (3) @(negedge clk);

    // R8
    sysflt1 = 1'b1;
    repeat (3) @(negedge clk);
    check(bb(13) | bb(15), "R8 sysflt1 pair");
    // R9 sticky: accumulate with a bus fault
    bus_cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    check(bb(13) | bb(15) | bb(2), "R9 sticky accumulate");
    sysflt1 = 1'b0;

    // R10: parity fault ends on the same edge as clear
    @(negedge clk);
    busy_n = 1'b0; parity_err_n = 1'b0;
    @(negedge clk);
    busy_n = 1'b1; parity_err_n = 1'b1; clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    check(bb(2), "R10 new fault wins over clear");
    do_clear();
    check(16'h0000, "R9 final clear");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule